// File: doc/BRIEF.md
# Dual programmable clock divider

This block takes one fast reference clock and produces two slower timing domains from it, a system domain and a core domain. Each domain is a clock enable: a pulse one reference cycle wide that marks the start of each divided period. Each domain also has a square wave at the same divided rate. The design never gates a clock. Downstream logic runs on the reference clock and qualifies its registers with the enables.

The system ratio is linear, from 1 to 15. The core ratio is a power of two, chosen by a 2-bit select. A single write port loads both fields together while the block is running. A newly written ratio is held in a shadow register. It becomes active only when the current divided period wraps, so both outputs keep running and no period is ever cut short. A write that carries a system ratio of zero is refused. The previous system ratio stays in force and an error flag is raised.

Top module: `clk_ratio_gen`

## Requirements
- R1: After a synchronous reset, `sys_ce`, `core_ce` and `sys_div_err` read 0. The system domain then runs at ratio 15 and the core domain at ratio 8.
- R2: With system ratio N (1 to 15), `sys_ce` is high for exactly one reference cycle in every N cycles, so consecutive pulses are N cycles apart.
- R3: The core select sets the core ratio: code 0 gives ratio 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. `core_ce` pulses once per ratio period.
- R4: For ratio N in either domain, the square output is high during the pulse cycle and for the following cycles, ceil(N/2) cycles in total. It is low for the rest of the period.
- R5: A ratio written in the middle of a period does not change that period, which ends after the old number of cycles. The period that starts at the next pulse uses the new ratio.
- R6: A write with `cfg_sys_div` = 0 leaves the system ratio unchanged and sets `sys_div_err` on the cycle after the write. The core select carried by the same write is still accepted.
- R7: A write with a nonzero `cfg_sys_div` clears `sys_div_err` on the cycle after the write.
- R8: With system ratio 1, `sys_ce` stays high on every reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe; loads both ratio fields in one cycle |
| cfg_sys_div | input | SYS_W | System ratio, legal values 1 to 2^SYS_W-1 |
| cfg_core_sel | input | 2 | Core ratio select (0:1, 1:2, 2:4, 3:8) |
| sys_ce | output | 1 | System clock enable pulse |
| sys_sq | output | 1 | System divided square wave |
| core_ce | output | 1 | Core clock enable pulse |
| core_sq | output | 1 | Core divided square wave |
| sys_div_err | output | 1 | Set by a write with system ratio 0, cleared by a valid write |

## Verification
The bench builds the block with its default SYS_W of 4. At that width the full legal system range can be reached, including the extreme ratios 1 and 15 and the reset ratio of 15, and every one of the four core select codes can be tried. Duty checks use both odd and even ratios, so the rounding of ceil(N/2) is exercised. Writes placed in the middle of a period show that the switch to a new ratio waits for the wrap.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Power-of-two core ratio select
  typedef enum logic [1:0] {
    CSEL_D1 = 2'd0,
    CSEL_D2 = 2'd1,
    CSEL_D4 = 2'd2,
    CSEL_D8 = 2'd3
  } core_sel_e;

  localparam int unsigned CORE_MAX_RATIO = 8;
  localparam int unsigned CORE_CW        = 4;

  function automatic logic [CORE_CW-1:0] core_sel_ratio(input core_sel_e s);
    logic [CORE_CW-1:0] r;
    r = CORE_CW'(1) << s;
    return r;
  endfunction

endpackage

// File: rtl/ratio_shadow.sv
module ratio_shadow
  import clkdiv_pkg::*;
#(
  parameter int unsigned SYS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SYS_W-1:0] wr_sys,
  input  core_sel_e        wr_core,
  output logic [SYS_W-1:0] sys_pend,
  output core_sel_e        core_pend,
  output logic             err
);

  localparam logic [SYS_W-1:0] SYS_SLOWEST = {SYS_W{1'b1}};

  logic sys_valid;
  assign sys_valid = (wr_sys != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_pend  <= SYS_SLOWEST;
      core_pend <= CSEL_D8;
      err       <= 1'b0;
    end else if (wr_en) begin
      core_pend <= wr_core;
      err       <= !sys_valid;
      if (sys_valid) sys_pend <= wr_sys;
    end
  end

  assert_zero_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sys == '0) |=> ($stable(sys_pend) && err));

  assert_valid_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sys != '0) |=> (!err && sys_pend == $past(wr_sys)));

  assert_pend_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    sys_pend != '0);

endmodule

// File: rtl/ratio_counter.sv
module ratio_counter #(
  parameter int unsigned CW        = 4,
  parameter int unsigned RST_RATIO = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ratio_pend,
  output logic          en,
  output logic          sq
);

  logic [CW-1:0] cnt, act;
  logic [CW-1:0] nxt_cnt, nxt_act;
  logic [CW:0]   half;
  logic          wrap;

  always_comb begin
    wrap    = (cnt == act - 1'b1);
    nxt_cnt = wrap ? '0 : cnt + 1'b1;
    nxt_act = wrap ? ratio_pend : act;
    half    = ({1'b0, nxt_act} + (CW+1)'(1)) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      act <= CW'(RST_RATIO);
      en  <= 1'b0;
      sq  <= 1'b0;
    end else begin
      cnt <= nxt_cnt;
      act <= nxt_act;
      en  <= wrap;
      sq  <= ({1'b0, nxt_cnt} < half);
    end
  end

  assert_cnt_below_ratio_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < act);

  assert_hold_between_wraps_R5: assert property (@(posedge clk) disable iff (rst)
    !en |-> $stable(act));

  assert_unit_ratio_R8: assert property (@(posedge clk) disable iff (rst)
    (act == CW'(1)) |=> en);

  assert_sq_on_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    en |-> sq);

endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clkdiv_pkg::*;
#(
  parameter int unsigned SYS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [SYS_W-1:0] cfg_sys_div,
  input  logic [1:0]       cfg_core_sel,
  output logic             sys_ce,
  output logic             sys_sq,
  output logic             core_ce,
  output logic             core_sq,
  output logic             sys_div_err
);

  localparam int unsigned SYS_SLOWEST = (1 << SYS_W) - 1;

  logic [SYS_W-1:0]   sys_pend;
  core_sel_e          core_pend;
  logic [CORE_CW-1:0] core_ratio;

  ratio_shadow #(.SYS_W(SYS_W)) shadow_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr),
    .wr_sys    (cfg_sys_div),
    .wr_core   (core_sel_e'(cfg_core_sel)),
    .sys_pend  (sys_pend),
    .core_pend (core_pend),
    .err       (sys_div_err)
  );

  assign core_ratio = core_sel_ratio(core_pend);

  ratio_counter #(.CW(SYS_W), .RST_RATIO(SYS_SLOWEST)) sys_div_i (
    .clk        (clk),
    .rst        (rst),
    .ratio_pend (sys_pend),
    .en         (sys_ce),
    .sq         (sys_sq)
  );

  ratio_counter #(.CW(CORE_CW), .RST_RATIO(CORE_MAX_RATIO)) core_div_i (
    .clk        (clk),
    .rst        (rst),
    .ratio_pend (core_ratio),
    .en         (core_ce),
    .sq         (core_sq)
  );

  assert_core_pulse_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!sys_ce && !core_ce && !sys_div_err));

endmodule

// File: tb/clk_ratio_gen_tb_top.sv
module clk_ratio_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_sys_div = 4'd0;
  logic [1:0] cfg_core_sel = 2'd3;
  logic       sys_ce, sys_sq, core_ce, core_sq, sys_div_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_ratio_gen #(.SYS_W(4)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sys_div(cfg_sys_div),
    .cfg_core_sel(cfg_core_sel), .sys_ce(sys_ce), .sys_sq(sys_sq),
    .core_ce(core_ce), .core_sq(core_sq), .sys_div_err(sys_div_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit pulse(input int dom);
    return (dom == 0) ? sys_ce : core_ce;
  endfunction

  function automatic bit square(input int dom);
    return (dom == 0) ? sys_sq : core_sq;
  endfunction

  task automatic wait_pulse(input int dom);
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!pulse(dom) && g < 100);
  endtask

  task automatic interval(input int dom, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse(dom) && n < 100);
  endtask

  task automatic write_cfg(input logic [3:0] s, input logic [1:0] c);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sys_div = s; cfg_core_sel = c;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic settled_period(input int dom, output int n);
    wait_pulse(dom);
    wait_pulse(dom);
    interval(dom, n);
  endtask

  task automatic t_reset;
    int n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!sys_ce && !core_ce && !sys_div_err, "R1 reset outputs",
          {29'd0, sys_ce, core_ce, sys_div_err}, 0);
    wait_pulse(0); interval(0, n);
    check(n == 15, "R1 reset system period", n, 15);
    wait_pulse(1); interval(1, n);
    check(n == 8, "R1 reset core period", n, 8);
  endtask

  task automatic t_sys_ratios;
    int list[6] = '{2, 3, 7, 15, 14, 5};
    int n;
    foreach (list[i]) begin
      write_cfg(4'(list[i]), 2'd3);
      settled_period(0, n);
      check(n == list[i], $sformatf("R2 system period ratio %0d", list[i]), n, list[i]);
    end
  endtask

  task automatic t_core;
    int n;
    for (int c = 0; c < 4; c++) begin
      write_cfg(4'd4, 2'(c));
      settled_period(1, n);
      check(n == (1 << c), $sformatf("R3 core period code %0d", c), n, 1 << c);
    end
  endtask

  task automatic duty(input int dom, input int ratio, input string tag);
    int h = 0;
    wait_pulse(dom);
    wait_pulse(dom);
    for (int i = 0; i < ratio; i++) begin
      if (square(dom)) h++;
      @(negedge clk);
    end
    check(h == (ratio + 1) / 2, tag, h, (ratio + 1) / 2);
  endtask

  task automatic t_duty;
    int list[5] = '{1, 2, 5, 8, 15};
    foreach (list[i]) begin
      write_cfg(4'(list[i]), 2'd2);
      duty(0, list[i], $sformatf("R4 system duty ratio %0d", list[i]));
    end
    duty(1, 4, "R4 core duty ratio 4");
    write_cfg(4'd3, 2'd3);
    duty(1, 8, "R4 core duty ratio 8");
  endtask

  task automatic t_wrap;
    int n;
    write_cfg(4'd10, 2'd3);
    wait_pulse(0);
    wait_pulse(0);
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    write_cfg(4'd4, 2'd3);
    n += 2;
    while (!sys_ce && n < 100) begin @(negedge clk); n++; end
    check(n == 10, "R5 period in progress keeps old ratio", n, 10);
    interval(0, n);
    check(n == 4, "R5 next period uses new ratio", n, 4);
  endtask

  task automatic t_zero;
    int n;
    write_cfg(4'd6, 2'd1);
    wait_pulse(0);
    write_cfg(4'd0, 2'd2);
    check(sys_div_err == 1'b1, "R6 error flag set", sys_div_err, 1);
    settled_period(0, n);
    check(n == 6, "R6 system ratio held", n, 6);
    interval(0, n);
    check(n == 6, "R6 system ratio held again", n, 6);
    settled_period(1, n);
    check(n == 4, "R6 core field still taken", n, 4);
    write_cfg(4'd9, 2'd2);
    check(sys_div_err == 1'b0, "R7 error flag cleared", sys_div_err, 0);
    settled_period(0, n);
    check(n == 9, "R7 valid ratio applied", n, 9);
  endtask

  task automatic t_one;
    int hi = 0;
    write_cfg(4'd1, 2'd0);
    wait_pulse(0);
    wait_pulse(0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sys_ce && core_ce) hi++;
    end
    check(hi == 20, "R8 continuous enable at ratio 1", hi, 20);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sys_ratios();
    t_core();
    t_duty();
    t_wrap();
    t_zero();
    t_one();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule